// File: doc/BRIEF.md
# Bus Ownership Requester

This block sits on a master card between a processor that uses a hold/acknowledge handshake and a backplane arbiter that grants over a daisy chain. The card has one arbitration level to itself. Its request line on that level is therefore driven all the time. The top level of the four is kept for a separate console master, and the block never requests on it.

After reset the block does not claim the bus. Until the processor first asks for an external cycle, it forwards any grant that reaches it down the chain one clock later. Once the processor has asked, the block keeps the grant for itself. It takes ownership when the grant is present and the backplane busy line is idle. It then drives busy and releases the processor from hold. If the arbiter removes the grant, the processor does not give the bus back by itself, so the block asserts hold. It keeps ownership until the processor acknowledges hold, which the processor only does at a cycle boundary.

A single ownership level enables the data buffers and turns the address buffers toward the backplane. When the card is not the owner, the address buffers point inward so that the processor can watch other masters' cycles and keep its cache coherent. Everything runs on the processor clock.

Top module: `bus_owner_fsm`

## Requirements
- R1: While reset is active and on the first clock after it, cpu_hold is 1, and grant_out, busy_out, data_buf_en and addr_to_bus are all 0.
- R2: bus_req is one-hot with its single 1 at bit LEVEL (default 1), and bit LEVELS-1 is never driven. This holds at all times, including during reset.
- R3: Before the first clock edge after reset at which cpu_breq is sampled high, grant_out equals the value of (grant_in AND NOT cpu_breq) sampled at the previous edge. No ownership is taken in this phase, even when grant_in is 1 and busy_in is 0.
- R4: After cpu_breq has been sampled high once, the block takes ownership one clock after an edge at which grant_in is 1 and busy_in is 0. At that point data_buf_en and busy_out rise and cpu_hold falls.
- R5: While waiting for ownership, an edge at which grant_in is 0 or busy_in is 1 leaves data_buf_en and busy_out at 0 and cpu_hold at 1.
- R6: If grant_in is 0 at an edge while the card owns the bus, cpu_hold is 1 from the next clock. Ownership (data_buf_en, busy_out) stays in place for as long as cpu_hlda is sampled 0.
- R7: While the card is giving up the bus with cpu_hold at 1, one clock after an edge at which cpu_hlda is 1, data_buf_en, addr_to_bus and busy_out fall together.
- R8: addr_to_bus (1 = addresses driven outward, 0 = inward for snooping) is equal to data_buf_en at every clock.
- R9: Once cpu_breq has been sampled high after reset, grant_out stays 0 for any grant_in and busy_in until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_breq | input | 1 | Processor has an external cycle pending |
| cpu_hlda | input | 1 | Processor acknowledges hold (at a cycle boundary) |
| grant_in | input | 1 | Daisy-chain grant arriving on this card's level |
| busy_in | input | 1 | Backplane busy line as observed |
| cpu_hold | output | 1 | Hold request to the processor |
| grant_out | output | 1 | Grant passed down the chain |
| busy_out | output | 1 | Busy driven by this card |
| data_buf_en | output | 1 | Data buffer enable, high when the card owns the bus |
| addr_to_bus | output | 1 | Address buffer direction, 1 drives outward |
| bus_req | output | LEVELS | Per-level requests, constant one-hot |

## Verification
Before arming, all four combinations of grant_in and cpu_breq are applied. This separates a forwarded grant from a grant the block keeps for itself. After arming, every combination of grant_in and busy_in is applied to the waiting block. Only grant present with busy idle may lead to ownership. Withdrawal of the grant is tried with the hold acknowledge delayed by zero to three clocks, to show that ownership lasts exactly until the acknowledge. A reacquire afterwards, and a grant offered after release, show that the card neither loses the ability to take the bus nor starts forwarding the grant again.

// File: rtl/bus_owner_fsm.sv
module bus_owner_fsm #(
  parameter int LEVELS = 4,
  parameter int LEVEL  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_breq,
  input  logic              cpu_hlda,
  input  logic              grant_in,
  input  logic              busy_in,
  output logic              cpu_hold,
  output logic              grant_out,
  output logic              busy_out,
  output logic              data_buf_en,
  output logic              addr_to_bus,
  output logic [LEVELS-1:0] bus_req
);

  localparam int USE_LEVEL = (LEVEL >= LEVELS - 1) ? LEVELS - 2 : LEVEL;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_OWN, S_DROP} state_t;

  state_t st, st_nx;
  logic   grant_q;
  logic   owner;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (cpu_breq) st_nx = S_WAIT;
      S_WAIT: if (grant_in && !busy_in) st_nx = S_OWN;
      S_OWN:  if (!grant_in) st_nx = S_DROP;
      S_DROP: if (cpu_hlda) st_nx = S_WAIT;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      grant_q <= 1'b0;
    end else begin
      st      <= st_nx;
      grant_q <= (st == S_IDLE) && !cpu_breq && grant_in;
    end
  end

  assign owner       = (st == S_OWN) || (st == S_DROP);
  assign busy_out    = owner;
  assign data_buf_en = owner;
  assign addr_to_bus = owner;
  assign cpu_hold    = (st != S_OWN);
  assign grant_out   = grant_q;

  always_comb begin
    bus_req = '0;
    bus_req[USE_LEVEL] = 1'b1;
  end

  p_take_needs_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_buf_en) |-> $past(grant_in) && !$past(busy_in));

  p_hold_on_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_buf_en && !grant_in) |=> cpu_hold);

  p_keep_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_buf_en && cpu_hold && !cpu_hlda) |=> data_buf_en);

  p_release_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_buf_en) |-> $past(cpu_hlda) && $past(cpu_hold));

  p_pass_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_out |-> $past(grant_in) && !data_buf_en);

  p_no_pass_after_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_breq |=> !grant_out);

endmodule

// File: tb/sim_bus_owner_fsm.sv
module sim_bus_owner_fsm;
  localparam int LEVELS = 4;
  localparam int LEVEL  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_breq = 1'b0, cpu_hlda = 1'b1, grant_in = 1'b0, busy_in = 1'b0;
  logic cpu_hold, grant_out, busy_out, data_buf_en, addr_to_bus;
  logic [LEVELS-1:0] bus_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_owner_fsm #(.LEVELS(LEVELS), .LEVEL(LEVEL)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_breq(cpu_breq), .cpu_hlda(cpu_hlda),
    .grant_in(grant_in), .busy_in(busy_in), .cpu_hold(cpu_hold),
    .grant_out(grant_out), .busy_out(busy_out), .data_buf_en(data_buf_en),
    .addr_to_bus(addr_to_bus), .bus_req(bus_req));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic own_chk(input string req, input int exp);
    chk(req, data_buf_en, exp);
    chk(req, busy_out, exp);
    chk({req, " R8"}, addr_to_bus, data_buf_en);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_breq = 1'b0; cpu_hlda = 1'b1; grant_in = 1'b0; busy_in = 1'b0;
    @(negedge clk);
    chk("R1 hold", cpu_hold, 1);
    chk("R1 gout", grant_out, 0);
    own_chk("R1 own", 0);
    chk("R2 req", bus_req, 1 << LEVEL);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hold after", cpu_hold, 1);
    own_chk("R1 own after", 0);
  endtask

  task automatic arm();
    cpu_breq = 1'b1; grant_in = 1'b0; busy_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R3: forwarding before the first processor request
    for (int p = 0; p < 4; p++) begin
      do_reset();
      grant_in = p[0]; cpu_breq = p[1];
      @(negedge clk);
      chk("R3 forward", grant_out, p[0] & ~p[1]);
      own_chk("R3 no own", 0);
    end
    do_reset();
    grant_in = 1'b1;
    repeat (4) @(negedge clk);
    own_chk("R3 idle grant no own", 0);
    chk("R3 still forwarding", grant_out, 1);

    // R4 / R5: every grant/busy combination after arming
    for (int p = 0; p < 4; p++) begin
      do_reset();
      arm();
      grant_in = p[0]; busy_in = p[1];
      @(negedge clk);
      if (p[0] && !p[1]) begin
        own_chk("R4 take", 1);
        chk("R4 hold low", cpu_hold, 0);
      end else begin
        own_chk("R5 wait", 0);
        chk("R5 hold high", cpu_hold, 1);
      end
      chk("R9 no forward", grant_out, 0);
      chk("R2 req", bus_req, 1 << LEVEL);
    end

    // R6 / R7: grant withdrawn, acknowledge delayed 0..3 clocks
    for (int n = 0; n < 4; n++) begin
      do_reset();
      arm();
      grant_in = 1'b1;
      @(negedge clk);
      cpu_hlda = 1'b0;
      @(negedge clk);
      own_chk("R4 owned", 1);
      grant_in = 1'b0;
      @(negedge clk);
      chk("R6 hold", cpu_hold, 1);
      own_chk("R6 keep", 1);
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        own_chk("R6 keep wait", 1);
      end
      cpu_hlda = 1'b1;
      @(negedge clk);
      own_chk("R7 release", 0);
      chk("R7 hold", cpu_hold, 1);
      grant_in = 1'b1; busy_in = 1'b1;
      @(negedge clk);
      own_chk("R5 busy after release", 0);
      chk("R9 no forward after release", grant_out, 0);
      busy_in = 1'b0;
      @(negedge clk);
      own_chk("R4 reacquire", 1);
      chk("R4 hold low again", cpu_hold, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule